// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer

An 8-bit up-counter for a small microcontroller. One count source is picked from three internal prescaled tick lines or from edges of an external clock pin. The counter value is checked against two compare registers, A and B. A match sets a sticky flag, can clear the counter, and can change one waveform output pin. A counter wrap sets an overflow flag. Each flag has its own enable, and the enabled flags are ORed into a single interrupt request.

The counter can also be cleared by a rising edge on an external reset pin. In trigger mode, any clear stops the counter at zero. Counting resumes only when a chosen edge arrives on a trigger pin. The external pins are asynchronous. Each one passes through a two-flop synchronizer before its edges are detected. Control values are plain input ports, and the prescaler that makes the tick lines sits outside the block.

Top module: `dual_cmp_timer8`

## Requirements
- R1: After reset the counter is 0, all three flags are 0, `irq_o` is 0 and `wave_o` is 0.
- R2: `clk_sel_i` picks the count event: 0 and 7 mean none; 1, 2 and 3 mean `tick_i[0]`, `tick_i[1]` and `tick_i[2]` sampled high; 4, 5 and 6 mean a rising, falling or either edge of the synchronized `ext_clk_i`. The counter adds one per event and holds without one.
- R3: A count event at 0xFF that is not a clear makes the counter 0 and sets `ovf_o` on the same edge. A clear that forces 0xFF to 0 does not set `ovf_o`.
- R4: Match A (or B) fires when the counter equals `cmp_a_i` (or `cmp_b_i`) and a count event occurs, so it falls in the last cycle of that value. A held value with no count event sets no flag. The flag `cmfa_o` (or `cmfb_o`) rises on the edge that ends the match cycle.
- R5: Flags stay set until a pulse on `flag_clr_i` clears them (bit 0 overflow, bit 1 A, bit 2 B). A set and a clear on the same edge leave the flag set.
- R6: `irq_o` is high whenever a flag is set and its enable (`ovf_ie_i`, `cma_ie_i`, `cmb_ie_i`) is 1. It is low when no enabled flag is set.
- R7: `out_sel_i[1:0]` sets the response to match A and `out_sel_i[3:2]` the response to match B: 00 keep, 01 drive 0, 10 drive 1, 11 toggle. `wave_o` changes on the edge that ends the match cycle. When both matches occur together, B's action wins unless B's action is keep.
- R8: When `clr_ctl_i` is 01 (or 10), a match A (or B) loads 0 into the counter instead of the increment. Code 00 leaves the count free-running through the matches.
- R9: When `clr_ctl_i` is 11, a rising edge of the synchronized `ext_rst_i` clears the counter. The pulse must be at least two clocks wide. With any other code the pin has no effect.
- R10: With `trig_en_i` at 1, any clear stops counting at 0. Counting restarts one clock after the edge chosen by `trig_edge_i` is detected on the synchronized `trig_i`: 01 rising, 10 falling, 11 both, 00 none. An edge that was not chosen has no effect.
- R11: With `trig_en_i` at 0, a clear does not stop counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 3 | Internal prescaled count ticks |
| clk_sel_i | input | 3 | Count source select |
| ext_clk_i | input | 1 | External count clock pin (asynchronous) |
| ext_rst_i | input | 1 | External counter reset pin (asynchronous) |
| trig_i | input | 1 | Trigger pin for restart (asynchronous) |
| cmp_a_i | input | 8 | Compare value A |
| cmp_b_i | input | 8 | Compare value B |
| clr_ctl_i | input | 2 | Clear source: 00 none, 01 A, 10 B, 11 pin |
| trig_en_i | input | 1 | Trigger mode enable |
| trig_edge_i | input | 2 | Restart edge select |
| out_sel_i | input | 4 | Output action for match B [3:2] and A [1:0] |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cma_ie_i | input | 1 | Match A interrupt enable |
| cmb_ie_i | input | 1 | Match B interrupt enable |
| flag_clr_i | input | 3 | Flag clear pulses (B, A, overflow) |
| cnt_o | output | 8 | Counter value |
| ovf_o | output | 1 | Overflow flag |
| cmfa_o | output | 1 | Match A flag |
| cmfb_o | output | 1 | Match B flag |
| irq_o | output | 1 | Gated interrupt request |
| wave_o | output | 1 | Waveform output pin |

## Verification
The count path is tried with each source setting. A tick line held high is compared with one held low, which shows whether the selection decodes correctly. External pulse trains are counted in rising, falling and both-edge modes, which separates the three edge detectors. Compare tests stop the counter on a match value and then step it once, which shows whether a match is tied to the count event or only to equality. Clear tests use each clear code and compare value 0xFF, which tells a clear-forced zero from a wrap. Trigger tests apply a non-chosen edge and then the chosen one, and follow the count cycle by cycle after the restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } wave_act_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'b00,
    CLR_ON_A   = 2'b01,
    CLR_ON_B   = 2'b10,
    CLR_ON_PIN = 2'b11
  } clr_mode_e;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_TICK0    = 3'd1,
    SRC_TICK1    = 3'd2,
    SRC_TICK2    = 3'd3,
    SRC_EXT_RISE = 3'd4,
    SRC_EXT_FALL = 3'd5,
    SRC_EXT_BOTH = 3'd6,
    SRC_OFF_HI   = 3'd7
  } src_sel_e;

  localparam int NUM_TICKS = 3;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_A    = 1;
  localparam int FLAG_B    = 2;

  localparam int NUM_PINS  = 3;
  localparam int PIN_CLK   = 0;
  localparam int PIN_RST   = 1;
  localparam int PIN_TRIG  = 2;

  // bit 0 of sel accepts a rising edge, bit 1 a falling edge
  function automatic logic edge_pick(input logic [1:0] sel,
                                     input logic lvl, input logic last);
    return (sel[0] & lvl & ~last) | (sel[1] & ~lvl & last);
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic last_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign last_o = last_q;

  // R2: the delayed copy always follows the synchronized level by one clock
  a_r2_last_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> last_o == $past(lvl_o));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_step_i,
  input  logic         trig_en_i,
  input  logic         trig_go_i,
  input  clr_mode_e    clr_mode_i,
  input  logic         match_a_i,
  input  logic         match_b_i,
  input  logic         pin_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         step_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         halt_q, halt_d;
  logic         clr_now;

  always_comb begin
    step_o  = src_step_i & ~(trig_en_i & halt_q);
    clr_now = ((clr_mode_i == CLR_ON_A)   & match_a_i) |
              ((clr_mode_i == CLR_ON_B)   & match_b_i) |
              ((clr_mode_i == CLR_ON_PIN) & pin_clr_i);
    wrap_o  = step_o & (cnt_q == CNT_MAX) & ~clr_now;

    if (clr_now)     cnt_d = '0;
    else if (step_o) cnt_d = cnt_q + W'(1);
    else             cnt_d = cnt_q;

    if (!trig_en_i)     halt_d = 1'b0;
    else if (clr_now)   halt_d = 1'b1;
    else if (trig_go_i) halt_d = 1'b0;
    else                halt_d = halt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: no source event and no clear leaves the count alone
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_step_i && !clr_now) |=> $stable(cnt_o));

  // R3: a wrap event lands the counter on zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_o == '0);

  // R8: a selected clear loads zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> cnt_o == '0);

  // R10: while halted in trigger mode the count never advances
  a_r10_halted_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en_i && halt_q) |=> ($stable(cnt_o) || cnt_o == '0));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      if (set_i[g])      flag_d = 1'b1;
      else if (clr_i[g]) flag_d = 1'b0;
      else               flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign flag_o[g] = flag_q;

    // R5: a set event wins over a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);

    // R5: a flag stays up until a clear pulse arrives
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
  end

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      match_a_i,
  input  logic      match_b_i,
  input  wave_act_e act_a_i,
  input  wave_act_e act_b_i,
  output logic      wave_o
);

  wave_act_e act;
  logic      wave_q, wave_d;

  always_comb begin
    if (match_b_i && act_b_i != ACT_KEEP) act = act_b_i;
    else if (match_a_i)                   act = act_a_i;
    else                                  act = ACT_KEEP;

    case (act)
      ACT_LOW:    wave_d = 1'b0;
      ACT_HIGH:   wave_d = 1'b1;
      ACT_TOGGLE: wave_d = ~wave_q;
      default:    wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave_o = wave_q;

  // R7: no match, no change on the pin
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a_i && !match_b_i) |=> $stable(wave_o));

  // R7: match A alone with drive-low selected
  a_r7_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && !match_b_i && act_a_i == ACT_LOW) |=> !wave_o);

  // R7: match B with drive-high selected wins
  a_r7_b_high: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b_i && act_b_i == ACT_HIGH) |=> wave_o);

  // R7: toggle on match A alone inverts the pin
  a_r7_a_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && !match_b_i && act_a_i == ACT_TOGGLE) |=> wave_o != $past(wave_o));

endmodule

// File: rtl/dual_cmp_timer8.sv
module dual_cmp_timer8
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   tick_i,
  input  logic [2:0]   clk_sel_i,
  input  logic         ext_clk_i,
  input  logic         ext_rst_i,
  input  logic         trig_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic [1:0]   clr_ctl_i,
  input  logic         trig_en_i,
  input  logic [1:0]   trig_edge_i,
  input  logic [3:0]   out_sel_i,
  input  logic         ovf_ie_i,
  input  logic         cma_ie_i,
  input  logic         cmb_ie_i,
  input  logic [2:0]   flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         cmfa_o,
  output logic         cmfb_o,
  output logic         irq_o,
  output logic         wave_o
);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // pin synchronizers
  logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_last;
  assign pin_raw[PIN_CLK]  = ext_clk_i;
  assign pin_raw[PIN_RST]  = ext_rst_i;
  assign pin_raw[PIN_TRIG] = trig_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .d_i    (pin_raw[p]),
      .lvl_o  (pin_lvl[p]),
      .last_o (pin_last[p])
    );
  end

  // count source
  logic src_step;
  always_comb begin
    case (src_sel_e'(clk_sel_i))
      SRC_TICK0:    src_step = tick_i[0];
      SRC_TICK1:    src_step = tick_i[1];
      SRC_TICK2:    src_step = tick_i[2];
      SRC_EXT_RISE: src_step = edge_pick(2'b01, pin_lvl[PIN_CLK], pin_last[PIN_CLK]);
      SRC_EXT_FALL: src_step = edge_pick(2'b10, pin_lvl[PIN_CLK], pin_last[PIN_CLK]);
      SRC_EXT_BOTH: src_step = edge_pick(2'b11, pin_lvl[PIN_CLK], pin_last[PIN_CLK]);
      default:      src_step = 1'b0;
    endcase
  end

  logic pin_clr, trig_go;
  assign pin_clr = edge_pick(2'b01, pin_lvl[PIN_RST], pin_last[PIN_RST]);
  assign trig_go = edge_pick(trig_edge_i, pin_lvl[PIN_TRIG], pin_last[PIN_TRIG]);

  // counter and compares
  logic [W-1:0] cnt;
  logic         step, wrap, match_a, match_b;

  assign match_a = step & (cnt == cmp_a_i);
  assign match_b = step & (cnt == cmp_b_i);

  tmr_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .src_step_i (src_step),
    .trig_en_i  (trig_en_i),
    .trig_go_i  (trig_go),
    .clr_mode_i (clr_mode_e'(clr_ctl_i)),
    .match_a_i  (match_a),
    .match_b_i  (match_b),
    .pin_clr_i  (pin_clr),
    .cnt_o      (cnt),
    .step_o     (step),
    .wrap_o     (wrap)
  );

  // flags
  logic [NUM_FLAGS-1:0] flag_set, flags, flag_en;
  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVF] = wrap;
    flag_set[FLAG_A]   = match_a;
    flag_set[FLAG_B]   = match_b;
    flag_en            = '0;
    flag_en[FLAG_OVF]  = ovf_ie_i;
    flag_en[FLAG_A]    = cma_ie_i;
    flag_en[FLAG_B]    = cmb_ie_i;
  end

  tmr_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .flag_o (flags)
  );

  // waveform output
  tmr_wave u_wave (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .match_a_i (match_a),
    .match_b_i (match_b),
    .act_a_i   (wave_act_e'(out_sel_i[1:0])),
    .act_b_i   (wave_act_e'(out_sel_i[3:2])),
    .wave_o    (wave_o)
  );

  assign cnt_o  = cnt;
  assign ovf_o  = flags[FLAG_OVF];
  assign cmfa_o = flags[FLAG_A];
  assign cmfb_o = flags[FLAG_B];
  assign irq_o  = |(flags & flag_en);

  // R6: all enables off keeps the request low
  a_r6_masked: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!ovf_ie_i && !cma_ie_i && !cmb_ie_i) |-> !irq_o);

  // R4: a flag rises only after a match cycle
  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(cmfa_o) |-> $past(match_a));

  // R3: overflow flag rises only after a wrap event
  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(ovf_o) |-> $past(wrap));

endmodule

// File: tb/dual_cmp_timer8_tb.sv
module dual_cmp_timer8_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] tick_i, clk_sel_i, flag_clr_i;
  logic       ext_clk_i, ext_rst_i, trig_i;
  logic [7:0] cmp_a_i, cmp_b_i;
  logic [1:0] clr_ctl_i, trig_edge_i;
  logic       trig_en_i;
  logic [3:0] out_sel_i;
  logic       ovf_ie_i, cma_ie_i, cmb_ie_i;
  logic [7:0] cnt_o;
  logic       ovf_o, cmfa_o, cmfb_o, irq_o, wave_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clk_sel_i(clk_sel_i),
    .ext_clk_i(ext_clk_i), .ext_rst_i(ext_rst_i), .trig_i(trig_i),
    .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .clr_ctl_i(clr_ctl_i),
    .trig_en_i(trig_en_i), .trig_edge_i(trig_edge_i), .out_sel_i(out_sel_i),
    .ovf_ie_i(ovf_ie_i), .cma_ie_i(cma_ie_i), .cmb_ie_i(cmb_ie_i),
    .flag_clr_i(flag_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o), .cmfa_o(cmfa_o),
    .cmfb_o(cmfb_o), .irq_o(irq_o), .wave_o(wave_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_i = '0; clk_sel_i = '0; flag_clr_i = '0;
    ext_clk_i = 1'b0; ext_rst_i = 1'b0; trig_i = 1'b0;
    cmp_a_i = 8'd200; cmp_b_i = 8'd201;
    clr_ctl_i = 2'b00; trig_en_i = 1'b0; trig_edge_i = 2'b00;
    out_sel_i = 4'b0000; ovf_ie_i = 1'b0; cma_ie_i = 1'b0; cmb_ie_i = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic ext_pulses(input int n);
    repeat (n) begin
      ext_clk_i = 1'b1; cyc(4);
      ext_clk_i = 1'b0; cyc(4);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 cmfa", cmfa_o, 0);
    chk("R1 cmfb", cmfb_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 wave", wave_o, 0);
  endtask

  task automatic t_source();
    do_reset();
    tick_i = 3'b001;
    cyc(5);  chk("R2 sel off", cnt_o, 0);
    clk_sel_i = 3'd7; cyc(5); chk("R2 sel 7 off", cnt_o, 0);
    clk_sel_i = 3'd2; cyc(5); chk("R2 idle tick1", cnt_o, 0);
    clk_sel_i = 3'd1; cyc(10); chk("R2 tick0", cnt_o, 10);
    tick_i = 3'b100; clk_sel_i = 3'd3; cyc(4); chk("R2 tick2", cnt_o, 14);
    clk_sel_i = 3'd4; tick_i = '0;
    ext_pulses(3); chk("R2 ext rise", cnt_o, 17);
    clk_sel_i = 3'd5;
    ext_pulses(2); chk("R2 ext fall", cnt_o, 19);
    clk_sel_i = 3'd6;
    ext_pulses(2); chk("R2 ext both", cnt_o, 23);
  endtask

  task automatic t_overflow();
    do_reset();
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(255);
    chk("R3 at max", cnt_o, 255);
    chk("R3 no ovf yet", ovf_o, 0);
    flag_clr_i = 3'b001;
    cyc(1);
    flag_clr_i = 3'b000; clk_sel_i = 3'd0;
    chk("R3 wrapped", cnt_o, 0);
    chk("R5 set beats clear", ovf_o, 1);
    chk("R6 masked", irq_o, 0);
    ovf_ie_i = 1'b1; cyc(1);
    chk("R6 enabled", irq_o, 1);
    cyc(5);
    chk("R5 sticky", ovf_o, 1);
    flag_clr_i = 3'b001; cyc(1); flag_clr_i = 3'b000;
    chk("R5 cleared", ovf_o, 0);
    chk("R6 dropped", irq_o, 0);
  endtask

  task automatic t_compare();
    do_reset();
    cmp_a_i = 8'd5; clr_ctl_i = 2'b01;
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(5);
    chk("R4 reached 5", cnt_o, 5);
    chk("R4 not yet", cmfa_o, 0);
    clk_sel_i = 3'd0; cyc(4);
    chk("R4 held value no flag", cmfa_o, 0);
    clk_sel_i = 3'd1; cyc(1);
    chk("R8 clear on A", cnt_o, 0);
    chk("R4 flag A", cmfa_o, 1);
    cyc(6);
    chk("R8 period", cnt_o, 0);
    clk_sel_i = 3'd0; flag_clr_i = 3'b111; cyc(1); flag_clr_i = 3'b000;
    clr_ctl_i = 2'b10; cmp_b_i = 8'd3;
    clk_sel_i = 3'd1; cyc(3);
    chk("R4 B pending", cmfb_o, 0);
    cyc(1);
    chk("R8 clear on B", cnt_o, 0);
    chk("R4 flag B", cmfb_o, 1);
    chk("R4 no flag A", cmfa_o, 0);
    clk_sel_i = 3'd0;
    do_reset();
    cmp_a_i = 8'd5; tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(7);
    chk("R8 no clear code 00", cnt_o, 7);
    chk("R4 flag without clear", cmfa_o, 1);
    do_reset();
    cmp_a_i = 8'hFF; clr_ctl_i = 2'b01; tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(256);
    chk("R3 cleared at max", cnt_o, 0);
    chk("R3 clear not overflow", ovf_o, 0);
    chk("R3 match flag", cmfa_o, 1);
  endtask

  task automatic t_wave();
    do_reset();
    cmp_a_i = 8'd3; clr_ctl_i = 2'b01; out_sel_i = 4'b0011;
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(3); chk("R7 before match", wave_o, 0);
    cyc(1); chk("R7 toggle 1", wave_o, 1);
    cyc(4); chk("R7 toggle 2", wave_o, 0);
    cyc(4); chk("R7 toggle 3", wave_o, 1);
    out_sel_i = 4'b0001;
    cyc(4); chk("R7 drive low", wave_o, 0);
    cyc(4); chk("R7 drive low again", wave_o, 0);
    out_sel_i = 4'b0010;
    cyc(4); chk("R7 drive high", wave_o, 1);
    cmp_b_i = 8'd3; out_sel_i = 4'b0110;
    cyc(4); chk("R7 B wins", wave_o, 0);
    out_sel_i = 4'b0010;
    cyc(4); chk("R7 B keep lets A act", wave_o, 1);
    cmp_a_i = 8'd200; cmp_b_i = 8'd2; clr_ctl_i = 2'b10; out_sel_i = 4'b1100;
    cyc(3); chk("R7 B toggle", wave_o, 0);
  endtask

  task automatic t_pin_clear();
    do_reset();
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(20); clk_sel_i = 3'd0;
    chk("R9 preload", cnt_o, 20);
    ext_rst_i = 1'b1; cyc(2); ext_rst_i = 1'b0; cyc(5);
    chk("R9 pin ignored code 00", cnt_o, 20);
    clr_ctl_i = 2'b11;
    ext_rst_i = 1'b1; cyc(2); ext_rst_i = 1'b0; cyc(4);
    chk("R9 pin clear", cnt_o, 0);
  endtask

  task automatic t_trigger();
    do_reset();
    trig_en_i = 1'b1; trig_edge_i = 2'b10;
    cmp_a_i = 8'd3; clr_ctl_i = 2'b01;
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(4); chk("R10 cleared", cnt_o, 0);
    cyc(6); chk("R10 halted", cnt_o, 0);
    trig_i = 1'b1; cyc(5);
    chk("R10 wrong edge ignored", cnt_o, 0);
    trig_i = 1'b0;
    cyc(4); chk("R10 resumed", cnt_o, 1);
    cyc(2); chk("R10 counting", cnt_o, 3);
    cyc(1); chk("R10 cleared again", cnt_o, 0);
    cyc(5); chk("R10 halted again", cnt_o, 0);
    do_reset();
    cmp_a_i = 8'd3; clr_ctl_i = 2'b01;
    tick_i = 3'b001; clk_sel_i = 3'd1;
    cyc(4); chk("R11 cleared", cnt_o, 0);
    cyc(2); chk("R11 keeps counting", cnt_o, 2);
  endtask

  initial begin
    t_reset();
    t_source();
    t_overflow();
    t_compare();
    t_wave();
    t_pin_clear();
    t_trigger();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule